// File: doc/BRIEF.md
# Multiplexed I/O Register Address Mapper

This block sits between a bit-serial sensor/actuator bus scanner and a bank of host data registers. On every bus bit time the scanner presents the bus bit address, and the bus phase in host-controlled operation. The mapper then reports whether that bit has a home in the host register bank, which register index and bit position it uses, and whether the slot reads an input, drives an output, or does both. It also keeps the multiplex channel counter. This counter selects which channel of the multiplexed words is served during the current bus scan.

The bus is split into 16-bit words. The lowest word is never visible to the host. The plain (non-multiplexed) words come next, one register each, in rising address order. The multiplexed words take the top of the configured bus. Each multiplexed word takes one register per channel. Only a fixed number of data registers exist, and any slot past the last one reports "not mapped". The line driver then sends zero for such an output and discards such an input. A second alignment mode numbers the host bits MSB-first and starts them one address above the first visible word. This mode is meant for purely discrete I/O.

The outputs are registered, one clock after the address. The register storage, the decoding of the configuration word and the bus line drivers sit outside this block.

Top module: `mux_io_mapper`

## Requirements
- R1: The outputs follow `bit_valid` one clock later. When `bit_valid` was low, `slot_valid`, `slot_hit`, `slot_in` and `slot_out` are 0. Reset clears every output.
- R2: Bus addresses 0 to 15 are never mapped. Neither is any address at or above the configured bus size (`(size_code+1)*16` bits). In normal alignment, address 16 maps to register 0, bit 0.
- R3: In normal alignment, a plain word w (1 ≤ w ≤ `size_code - mux_words`) maps address `16*w + n` to register `w-1`, bit `n`.
- R4: The top `mux_words` words are multiplexed. Number them k = 0, 1, … upward from the first such word, and let P = `size_code - mux_words` be the count of plain registers. Then address bit n of word k on channel c maps to register `P + k*D + c`, bit n. D = `2 << depth_code` is the channel count (code 0..3 gives 2, 4, 8, 16).
- R5: A slot whose register index would be 31 or more is reported with `slot_hit` = 0. Whenever `slot_hit` is 0, `slot_reg` and `slot_bit` are 0.
- R6: With `discrete_mode` = 1, address a ≥ 17 maps to register `(a-17)/16`, bit `15 - (a-17)%16`. Address 16 is not mapped.
- R7: If `mux_words > size_code`, or if `mux_words` ≠ 0 while `discrete_mode` = 1, no address is mapped.
- R8: With `peer_mode` = 0, phase 0 (`bit_phase` = 0) gives an input-only slot and phase 1 gives an output-only slot. With `peer_mode` = 1, every slot is both input and output.
- R9: `scan_chan` advances by one after the last output slot of the last bus address (address `(size_code+1)*16-1`, on phase 1 when `peer_mode` = 0) while `bus_run` = 1. It wraps from D-1 to 0.
- R10: `scan_chan` becomes 0 one clock after `bus_run` is low, and one clock after `depth_code` changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_run | input | 1 | Bus is running; low halts and clears the channel |
| bit_valid | input | 1 | A bus bit time is presented this cycle |
| bit_addr | input | 8 | Bus bit address |
| bit_phase | input | 1 | Host-controlled phase: 0 input half, 1 output half |
| size_code | input | 4 | Bus size in 16-bit words minus one |
| mux_words | input | 4 | Number of multiplexed 16-bit words (0 = none) |
| depth_code | input | 2 | Channel count code, D = 2 << code |
| discrete_mode | input | 1 | 1 selects MSB-first discrete alignment |
| peer_mode | input | 1 | 1 selects peer operation (input and output every slot) |
| slot_valid | output | 1 | A mapping result is present |
| slot_hit | output | 1 | The bit has a host register |
| slot_reg | output | 5 | Host data register index |
| slot_bit | output | 4 | Bit position inside that register |
| slot_in | output | 1 | Slot samples the bus into the host |
| slot_out | output | 1 | Slot drives host data onto the bus |
| scan_chan | output | 4 | Multiplex channel being scanned |

## Verification
The assertions check, on every cycle, the one-clock valid timing, the absence of hits in the low word, at the discrete gap address and under a bad configuration, the register bound with zeroed unmapped fields, the slot direction rules of both modes, the channel bound, and the channel clearing on halt or depth change. The register and bit arithmetic of plain, multiplexed and discrete slots is checked by the bench's address sweeps, and so are truncation past the last register and the exact scan on which the channel advances and wraps. These sweeps cover every bus size against every multiplex width, and also run multi-scan sequences.

// File: rtl/mux_map_pkg.sv
package mux_map_pkg;

   // direction of one bus bit time as seen from the host
   typedef struct packed {
      logic in_slot;
      logic out_slot;
   } slot_dir_t;

   // channel count for a depth code
   function automatic int unsigned chan_count(input int unsigned code);
      return 32'd2 << code;
   endfunction

endpackage

// File: rtl/mux_slot_dir.sv
module mux_slot_dir
   import mux_map_pkg::*;
(
   input  logic      peer_mode,
   input  logic      bit_phase,
   output slot_dir_t dir
);

   always_comb begin
      if (peer_mode) begin
         dir.in_slot  = 1'b1;
         dir.out_slot = 1'b1;
      end else begin
         dir.in_slot  = ~bit_phase;
         dir.out_slot = bit_phase;
      end
   end

endmodule

// File: rtl/mux_chan_counter.sv
module mux_chan_counter #(
   parameter int DC_W = 2,
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_run,
   input  logic            scan_done,
   input  logic [DC_W-1:0] depth_code,
   output logic [CH_W-1:0] chan
);

   logic [DC_W-1:0] depth_q;
   logic [CH_W-1:0] chan_q;
   logic [CH_W-1:0] chan_last;

   always_comb begin
      chan_last = CH_W'((32'd2 << depth_code) - 32'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         chan_q  <= '0;
      end else begin
         depth_q <= depth_code;
         if (!bus_run || (depth_code != depth_q)) begin
            chan_q <= '0;
         end else if (scan_done) begin
            chan_q <= (chan_q == chan_last) ? '0 : chan_q + CH_W'(1);
         end
      end
   end

   assign chan = chan_q;

endmodule

// File: rtl/mux_addr_decode.sv
module mux_addr_decode #(
   parameter int WORD_BITS = 16,
   parameter int SIZE_W    = 4,
   parameter int DC_W      = 2,
   parameter int NREG      = 31,
   parameter bit DISC_EN   = 1'b1,
   localparam int BIT_W    = $clog2(WORD_BITS),
   localparam int ADDR_W   = BIT_W + SIZE_W,
   localparam int CH_W     = 1 << DC_W,
   localparam int REG_W    = $clog2(NREG)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CH_W-1:0]   chan,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [SIZE_W-1:0] mux_words,
   input  logic [DC_W-1:0]   depth_code,
   input  logic              disc_req,
   output logic              hit,
   output logic [REG_W-1:0]  reg_idx,
   output logic [BIT_W-1:0]  bit_pos
);

   localparam int WIDE_W = SIZE_W + CH_W + 2;
   localparam logic [ADDR_W-1:0] DISC_FIRST = ADDR_W'(WORD_BITS + 1);

   logic              disc;
   logic              disc_block;

   // variant: discrete alignment supported, or refused as a bad configuration
   generate
      if (DISC_EN) begin : g_disc
         assign disc       = disc_req;
         assign disc_block = 1'b0;
      end else begin : g_no_disc
         assign disc       = 1'b0;
         assign disc_block = disc_req;
      end
   endgenerate

   logic [SIZE_W-1:0] word;
   logic [BIT_W-1:0]  lane;
   logic [SIZE_W-1:0] plain_regs;
   logic [SIZE_W-1:0] mux_k;
   logic [ADDR_W-1:0] disc_off;
   logic [WIDE_W-1:0] r_sel;
   logic [BIT_W-1:0]  b_sel;
   logic              base_ok;
   logic              in_bus;
   logic              cfg_ok;

   assign word = addr[ADDR_W-1:BIT_W];
   assign lane = addr[BIT_W-1:0];

   always_comb begin
      plain_regs = size_code - mux_words;
      mux_k      = word - plain_regs - SIZE_W'(1);
      disc_off   = addr - DISC_FIRST;
      in_bus     = (word <= size_code);
      cfg_ok     = (mux_words <= size_code) && !(disc && (mux_words != '0)) && !disc_block;

      if (disc) begin
         base_ok = (addr >= DISC_FIRST);
         r_sel   = WIDE_W'(disc_off >> BIT_W);
         b_sel   = ~disc_off[BIT_W-1:0];
      end else if (word > plain_regs) begin
         base_ok = (word != '0);
         r_sel   = WIDE_W'(plain_regs)
                 + ((WIDE_W'(mux_k) << depth_code) << 1)
                 + WIDE_W'(chan);
         b_sel   = lane;
      end else begin
         base_ok = (word != '0);
         r_sel   = WIDE_W'(word) - WIDE_W'(1);
         b_sel   = lane;
      end

      hit     = cfg_ok && in_bus && base_ok && (r_sel < WIDE_W'(NREG));
      reg_idx = hit ? r_sel[REG_W-1:0] : '0;
      bit_pos = hit ? b_sel : '0;
   end

endmodule

// File: rtl/mux_io_mapper.sv
module mux_io_mapper
   import mux_map_pkg::*;
#(
   parameter int WORD_BITS = 16,
   parameter int SIZE_W    = 4,
   parameter int DC_W      = 2,
   parameter int NREG      = 31,
   parameter bit DISC_EN   = 1'b1,
   localparam int BIT_W    = $clog2(WORD_BITS),
   localparam int ADDR_W   = BIT_W + SIZE_W,
   localparam int CH_W     = 1 << DC_W,
   localparam int REG_W    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_run,
   input  logic              bit_valid,
   input  logic [ADDR_W-1:0] bit_addr,
   input  logic              bit_phase,
   input  logic [SIZE_W-1:0] size_code,
   input  logic [SIZE_W-1:0] mux_words,
   input  logic [DC_W-1:0]   depth_code,
   input  logic              discrete_mode,
   input  logic              peer_mode,
   output logic              slot_valid,
   output logic              slot_hit,
   output logic [REG_W-1:0]  slot_reg,
   output logic [BIT_W-1:0]  slot_bit,
   output logic              slot_in,
   output logic              slot_out,
   output logic [CH_W-1:0]   scan_chan
);

   // elaboration-time parameter checks
   generate
      if ((1 << BIT_W) != WORD_BITS) begin : g_bad_word
         $error("WORD_BITS must be a power of two");
      end
      if (DC_W < 1 || DC_W > 3) begin : g_bad_depth
         $error("DC_W must lie in 1..3");
      end
      if (NREG < 2 || NREG > (1 << REG_W)) begin : g_bad_nreg
         $error("NREG out of range");
      end
      if (SIZE_W < 1) begin : g_bad_size
         $error("SIZE_W must be at least 1");
      end
   endgenerate

   slot_dir_t          dir;
   logic               dec_hit;
   logic [REG_W-1:0]   dec_reg;
   logic [BIT_W-1:0]   dec_bit;
   logic               last_addr;
   logic               scan_done;

   mux_slot_dir u_dir (
      .peer_mode (peer_mode),
      .bit_phase (bit_phase),
      .dir       (dir)
   );

   assign last_addr = (bit_addr == {size_code, {BIT_W{1'b1}}});
   assign scan_done = bit_valid & bus_run & last_addr & dir.out_slot;

   mux_chan_counter #(
      .DC_W (DC_W),
      .CH_W (CH_W)
   ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_run    (bus_run),
      .scan_done  (scan_done),
      .depth_code (depth_code),
      .chan       (scan_chan)
   );

   mux_addr_decode #(
      .WORD_BITS (WORD_BITS),
      .SIZE_W    (SIZE_W),
      .DC_W      (DC_W),
      .NREG      (NREG),
      .DISC_EN   (DISC_EN)
   ) u_dec (
      .addr       (bit_addr),
      .chan       (scan_chan),
      .size_code  (size_code),
      .mux_words  (mux_words),
      .depth_code (depth_code),
      .disc_req   (discrete_mode),
      .hit        (dec_hit),
      .reg_idx    (dec_reg),
      .bit_pos    (dec_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_valid <= 1'b0;
         slot_hit   <= 1'b0;
         slot_reg   <= '0;
         slot_bit   <= '0;
         slot_in    <= 1'b0;
         slot_out   <= 1'b0;
      end else begin
         slot_valid <= bit_valid;
         slot_hit   <= bit_valid & dec_hit;
         slot_reg   <= bit_valid ? dec_reg : '0;
         slot_bit   <= bit_valid ? dec_bit : '0;
         slot_in    <= bit_valid & dir.in_slot;
         slot_out   <= bit_valid & dir.out_slot;
      end
   end

endmodule

// File: rtl/mux_io_mapper_chk.sv
module mux_io_mapper_chk #(
   parameter int WORD_BITS = 16,
   parameter int SIZE_W    = 4,
   parameter int DC_W      = 2,
   parameter int NREG      = 31,
   localparam int BIT_W    = $clog2(WORD_BITS),
   localparam int ADDR_W   = BIT_W + SIZE_W,
   localparam int CH_W     = 1 << DC_W,
   localparam int REG_W    = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_run,
   input logic              bit_valid,
   input logic [ADDR_W-1:0] bit_addr,
   input logic [SIZE_W-1:0] size_code,
   input logic [SIZE_W-1:0] mux_words,
   input logic [DC_W-1:0]   depth_code,
   input logic              discrete_mode,
   input logic              peer_mode,
   input logic              slot_valid,
   input logic              slot_hit,
   input logic [REG_W-1:0]  slot_reg,
   input logic [BIT_W-1:0]  slot_bit,
   input logic              slot_in,
   input logic              slot_out,
   input logic [CH_W-1:0]   scan_chan
);

   AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |=> slot_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> (!slot_valid && !slot_hit && !slot_in && !slot_out)); // R1
   AST_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && (32'(bit_addr) < WORD_BITS)) |=> !slot_hit); // R2
   AST_REG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      slot_hit |-> (32'(slot_reg) < NREG)); // R5
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_hit |-> (slot_reg == '0 && slot_bit == '0)); // R5
   AST_DISC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && discrete_mode && (32'(bit_addr) == WORD_BITS)) |=> !slot_hit); // R6
   AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && ((mux_words > size_code) || (discrete_mode && mux_words != '0))) |=> !slot_hit); // R7
   AST_HOST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !peer_mode) |=> (slot_in != slot_out)); // R8
   AST_PEER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && peer_mode) |=> (slot_in && slot_out)); // R8
   AST_CHAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bus_run |=> (32'(scan_chan) < (32'd2 << depth_code))); // R9
   AST_HALT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_run |=> (scan_chan == '0)); // R10
   AST_DEPTH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(depth_code) |=> (scan_chan == '0)); // R10

endmodule

bind mux_io_mapper mux_io_mapper_chk #(
   .WORD_BITS (WORD_BITS),
   .SIZE_W    (SIZE_W),
   .DC_W      (DC_W),
   .NREG      (NREG)
) u_chk (.*);

// File: tb/mux_io_mapper_bench.sv
module mux_io_mapper_bench;

   localparam int AW = 8;
   localparam int SW = 4;
   localparam int DW = 2;
   localparam int RW = 5;
   localparam int BW = 4;
   localparam int CW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          bus_run = 1'b0;
   logic          bit_valid = 1'b0;
   logic [AW-1:0] bit_addr = '0;
   logic          bit_phase = 1'b0;
   logic [SW-1:0] size_code = '0;
   logic [SW-1:0] mux_words = '0;
   logic [DW-1:0] depth_code = '0;
   logic          discrete_mode = 1'b0;
   logic          peer_mode = 1'b0;
   logic          slot_valid, slot_hit, slot_in, slot_out;
   logic [RW-1:0] slot_reg;
   logic [BW-1:0] slot_bit;
   logic [CW-1:0] scan_chan;

   mux_io_mapper u_mux_io_mapper (.*);

   int n_cmp = 0;
   int n_bad = 0;

   // staged inputs, applied right after each check
   int nx_sz = 0, nx_mw = 0, nx_dc = 0;
   bit nx_disc = 0, nx_peer = 0, nx_run = 0;

   // model state
   int    m_chan = 0;
   int    prev_dc = 0;
   string ch_tag = "R10";
   bit    p_on = 0;
   bit    p_valid, p_hit, p_in, p_out;
   int    p_reg, p_bit;
   string p_tag = "R1";

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic void model(input int a, input int ch, input int sz, input int mw,
                                 input int dc, input bit disc, output bit hit,
                                 output int r, output int b, output string tag);
      int bits;
      int plain;
      bits = (sz + 1) * 16;
      hit = 0; r = 0; b = 0;
      if (a >= bits) begin tag = "R2"; return; end
      if (disc) begin
         if (mw != 0) begin tag = "R7"; return; end
         tag = "R6";
         if (a < 17) return;
         r = (a - 17) / 16;
         b = 15 - ((a - 17) % 16);
         hit = 1;
         return;
      end
      if (mw > sz) begin tag = "R7"; return; end
      if (a < 16) begin tag = "R2"; return; end
      plain = sz - mw;
      if (a / 16 <= plain) begin
         tag = (a / 16 == 1) ? "R2" : "R3";
         r = a / 16 - 1; b = a % 16; hit = 1;
         return;
      end
      r = plain + (a / 16 - plain - 1) * (2 << dc) + ch;
      b = a % 16;
      if (r >= 31) begin tag = "R5"; r = 0; b = 0; return; end
      tag = "R4"; hit = 1;
   endfunction

   task automatic check_pending();
      if (p_on) begin
         cmp("R1", "valid", int'(slot_valid), int'(p_valid));
         cmp(p_tag, "hit", int'(slot_hit), int'(p_hit));
         cmp(p_hit ? p_tag : "R5", "reg", int'(slot_reg), p_reg);
         cmp(p_hit ? p_tag : "R5", "bit", int'(slot_bit), p_bit);
         cmp("R8", "in", int'(slot_in), int'(p_in));
         cmp("R8", "out", int'(slot_out), int'(p_out));
      end
      cmp(ch_tag, "chan", int'(scan_chan), m_chan);
   endtask

   task automatic cyc(input bit v, input int a, input bit ph);
      @(negedge clk);
      check_pending();
      bus_run       = nx_run;
      size_code     = SW'(nx_sz);
      mux_words     = SW'(nx_mw);
      depth_code    = DW'(nx_dc);
      discrete_mode = nx_disc;
      peer_mode     = nx_peer;
      bit_valid     = v;
      bit_addr      = AW'(a);
      bit_phase     = ph;
      p_on    = 1;
      p_valid = v;
      if (v) begin
         model(a, m_chan, nx_sz, nx_mw, nx_dc, nx_disc, p_hit, p_reg, p_bit, p_tag);
         p_in  = nx_peer ? 1'b1 : !ph;
         p_out = nx_peer ? 1'b1 : ph;
      end else begin
         p_hit = 0; p_reg = 0; p_bit = 0; p_in = 0; p_out = 0; p_tag = "R1";
      end
      if (!nx_run || nx_dc != prev_dc) begin
         m_chan = 0; ch_tag = "R10";
      end else if (v && a == (nx_sz + 1) * 16 - 1 && (nx_peer || ph)) begin
         m_chan = (m_chan + 1) % (2 << nx_dc); ch_tag = "R9";
      end
      prev_dc = nx_dc;
   endtask

   task automatic cfg(input int sz, input int mw, input int dc, input bit disc, input bit peer);
      nx_sz = sz; nx_mw = mw; nx_dc = dc; nx_disc = disc; nx_peer = peer; nx_run = 0;
      cyc(0, 0, 0);
      nx_run = 1;
   endtask

   task automatic scan();
      int bits;
      bits = (nx_sz + 1) * 16;
      for (int a = 0; a < bits; a++) begin
         if (nx_peer) cyc(1, a, 0);
         else begin
            cyc(1, a, 0);
            cyc(1, a, 1);
         end
      end
      if (bits < 256) cyc(1, bits, 0);  // beyond the bus: R2
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R1
      cmp("R1", "reset valid", int'(slot_valid), 0);
      cmp("R1", "reset hit", int'(slot_hit), 0);
      cmp("R1", "reset reg", int'(slot_reg), 0);
      cmp("R10", "reset chan", int'(scan_chan), 0);

      // R2 R3 R4 R5 R7: every bus size against every mux width, peer mode
      for (int sz = 0; sz < 16; sz++) begin
         for (int mw = 0; mw < 16; mw++) begin
            cfg(sz, mw, (sz + mw) % 4, 0, 1);
            scan();
         end
      end

      // R6 R8: discrete alignment, host-controlled phases
      for (int sz = 0; sz < 16; sz++) begin
         cfg(sz, 0, 0, 1, 0);
         scan();
      end
      // R7: mux requested with discrete alignment
      cfg(4, 1, 0, 1, 1);
      scan();

      // R4 R9: four channels, host-controlled, wrap after four scans
      cfg(9, 8, 1, 0, 0);
      repeat (5) scan();
      // R5 R9: sixteen channels, truncation of upper words
      cfg(15, 15, 3, 0, 1);
      repeat (17) scan();
      // R9: two channels
      cfg(3, 2, 0, 0, 0);
      repeat (3) scan();

      // R10: depth change in mid-run clears the channel
      cfg(7, 3, 2, 0, 1);
      repeat (3) scan();
      nx_dc = 1;
      cyc(0, 0, 0);
      scan();
      scan();
      // R10: halt clears the channel
      nx_run = 0;
      cyc(0, 0, 0);
      nx_run = 1;
      cyc(0, 0, 0);
      cyc(0, 0, 0);
      @(negedge clk);
      check_pending();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule